// File: doc/BRIEF.md
# Write-Once Watchdog Timer

A countdown watchdog with a single writable control word. The first write after reset sets the whole setup: the reload count, the prescale choice, the run enable and the action taken on timeout. After that the setup is frozen. Every later write, whatever data it carries, only restarts the countdown from the frozen reload count. Software therefore cannot shorten, stretch or disable the timeout once the timer is armed.

The counting clock runs at half the bus clock rate. It is built as a clock enable. An optional prescaler slows each decrement by a further factor of 2**PRESC_LOG2 timer ticks (16384 by default). When the count reaches zero, the block sets a sticky expired flag. Depending on the latched action code, it then holds an interrupt level or pulses a reset request for one cycle. Both stay in that state until the next reset. A read port returns the frozen setup, the lock and expired flags, and the live count.

Top module: `wo_watchdog`

## Requirements
- R1: After reset, rd_data_o reads all zeros, and irq_o and rst_req_o are low.
- R2: The first write after reset latches wr_data_i as the setup. The fields are reload count [11:0], prescale select [12], enable [13] and action code [15:14]. The setup reads back unchanged on rd_data_o[15:0].
- R3: Once the setup is latched, later writes never change rd_data_o[15:0].
- R4: Any write before expiry loads the latched reload count into the counter and restarts the tick and prescale dividers, whatever the data. The full period then elapses again from that write.
- R5: A timer tick occurs every second bus clock. With prescale clear, each tick decrements the count by one, and the count is readable on rd_data_o[29:18].
- R6: With prescale set, the count decrements once every 2**PRESC_LOG2 timer ticks.
- R7: With enable set and reload N, expiry is visible exactly 2·N·D+1 bus clock edges after the arming or retrigger edge. D is 1 without prescale and 2**PRESC_LOG2 with prescale. The expired flag appears on rd_data_o[17].
- R8: With action code 2, irq_o goes high at expiry and stays high until reset, while rst_req_o stays low.
- R9: With any other action code, rst_req_o is high for exactly one cycle at expiry, while irq_o stays low.
- R10: With enable clear, the count holds at the reload value and no expiry ever occurs.
- R11: After expiry, writes have no effect: the count stays 0 and the flags and outputs are unchanged.
- R12: rd_data_o[16] reads 1 once the setup is latched, and rd_data_o[31:30] always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe to the control word |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 32 | Setup, lock and expired flags, live count |
| irq_o | output | 1 | Timeout interrupt level (action code 2) |
| rst_req_o | output | 1 | One-cycle timeout reset request (other action codes) |

## Verification
The live count and both flags are visible on the read port. A wrong divider phase or a missed restart therefore shows up as a count that is off at the first mid-period sample. It also moves the expiry edge away from the exact 2·N·D+1 cycle that the bench predicts. A lock that reopens shows up on the read-back as soon as a second write with different data arrives. A flag that is not sticky shows up one cycle after expiry, as an irq_o drop or a rst_req_o held too long.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned RELOAD_W = 12;
  localparam int unsigned CFG_W    = 16;
  localparam int unsigned RD_W     = 32;
  localparam logic [1:0]  ACT_IRQ  = 2'd2;

  typedef struct packed {
    logic [1:0]          action;
    logic                enable;
    logic                prescale;
    logic [RELOAD_W-1:0] reload;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output wdt_cfg_t         cfg_o,
  output logic             locked_o
);
  wdt_cfg_t cfg_q;
  logic     locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else if (wr_en_i && !locked_q) begin
      cfg_q    <= wdt_cfg_t'(wr_data_i);
      locked_q <= 1'b1;
    end
  end

  assign cfg_o    = cfg_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned TCLK_DIV_LOG2 = 1,
  parameter int unsigned PRESC_LOG2    = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic prescale_i,
  output logic dec_en_o
);
  logic [TCLK_DIV_LOG2-1:0] tdiv_q;
  logic [PRESC_LOG2-1:0]    presc_q;
  logic                     tick;

  assign tick = &tdiv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdiv_q  <= '0;
      presc_q <= '0;
    end else if (restart_i) begin
      tdiv_q  <= '0;
      presc_q <= '0;
    end else begin
      tdiv_q <= tdiv_q + 1'b1;
      if (tick && prescale_i) presc_q <= presc_q + 1'b1;
    end
  end

  assign dec_en_o = tick && (!prescale_i || (&presc_q));
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt
  import wdt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [RELOAD_W-1:0] load_val_i,
  input  logic                run_i,
  input  logic                dec_en_i,
  input  logic [1:0]          action_i,
  output logic [RELOAD_W-1:0] count_o,
  output logic                expired_o,
  output logic                irq_o,
  output logic                rst_req_o
);
  logic [RELOAD_W-1:0] cnt_q;
  logic                exp_q;
  logic                rreq_q;
  logic                hit;

  assign hit = run_i && !exp_q && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && dec_en_i && !exp_q && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      rreq_q <= hit && (action_i != ACT_IRQ);
      if (hit) exp_q <= 1'b1;
    end
  end

  assign count_o   = cnt_q;
  assign expired_o = exp_q;
  assign irq_o     = exp_q && (action_i == ACT_IRQ);
  assign rst_req_o = rreq_q;
endmodule

// File: rtl/wo_watchdog.sv
module wo_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned TCLK_DIV_LOG2 = 1,
  parameter int unsigned PRESC_LOG2    = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [RD_W-1:0]  rd_data_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  wdt_cfg_t            cfg;
  logic                locked;
  logic                expired;
  logic                load;
  logic                dec_en;
  logic [RELOAD_W-1:0] load_val;
  logic [RELOAD_W-1:0] count;

  wdt_cfg_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .cfg_o    (cfg),
    .locked_o (locked)
  );

  // first write loads straight from bus data; later writes from the frozen setup
  assign load     = wr_en_i && !expired;
  assign load_val = locked ? cfg.reload : wr_data_i[RELOAD_W-1:0];

  wdt_tick_gen #(
    .TCLK_DIV_LOG2(TCLK_DIV_LOG2),
    .PRESC_LOG2   (PRESC_LOG2)
  ) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load),
    .prescale_i(cfg.prescale),
    .dec_en_o  (dec_en)
  );

  wdt_down_cnt u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .run_i     (locked && cfg.enable),
    .dec_en_i  (dec_en),
    .action_i  (cfg.action),
    .count_o   (count),
    .expired_o (expired),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  assign rd_data_o = {2'b00, count, expired, locked, cfg};
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic                irq_o,
  input logic                rst_req_o,
  input logic                locked,
  input logic                expired,
  input wdt_cfg_t            cfg,
  input logic [RELOAD_W-1:0] count
);
  a_r1_idle_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked |-> (!irq_o && !rst_req_o && !expired));
  a_r3_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(cfg));
  a_r4_kick_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && wr_en_i && !expired) |=> (count == cfg.reload));
  a_r5_no_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (count <= $past(count)));
  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> irq_o);
  a_r9_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r9_outputs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o));
  a_r11_count_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired |=> (expired && count == '0));
endmodule

bind wo_watchdog wdt_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .irq_o    (irq_o),
  .rst_req_o(rst_req_o),
  .locked   (locked),
  .expired  (expired),
  .cfg      (cfg),
  .count    (count)
);

// File: tb/wo_watchdog_tb.sv
`timescale 1ns/1ps
module wo_watchdog_tb;
  localparam int unsigned PL = 2;
  localparam int unsigned PD = 1 << PL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [31:0] rd;
  logic        irq, rreq;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  wo_watchdog #(.TCLK_DIV_LOG2(1), .PRESC_LOG2(PL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd), .irq_o(irq), .rst_req_o(rreq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_edge(input int n, input bit ps);
    return 2 * n * (ps ? PD : 1) + 1;
  endfunction

  function automatic int exp_count(input int n, input bit ps, input int m);
    int c = n - m / (2 * (ps ? PD : 1));
    return (c < 0) ? 0 : c;
  endfunction

  function automatic logic [15:0] mk(input int n, input bit ps, input bit en, input int act);
    return {act[1:0], en, ps, n[11:0]};
  endfunction

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    waitn(3); rst_n = 1'b1; waitn(1);
  endtask

  task automatic run_case(input int n, input bit ps, input int act);
    int e, mid;
    logic [15:0] d;
    d = mk(n, ps, 1'b1, act);
    do_reset();
    wr(d);
    chk(rd[15:0] == d, "R2 setup readback", rd[15:0], d);
    chk(rd[16] == 1'b1, "R12 lock flag", rd[16], 1);
    e = exp_edge(n, ps);
    mid = e / 2;
    waitn(mid);
    chk(rd[29:18] == exp_count(n, ps, mid), ps ? "R6 prescaled count" : "R5 count",
        rd[29:18], exp_count(n, ps, mid));
    waitn(e - 1 - mid);
    chk(!irq && !rreq && !rd[17], "R7 no early expiry", {irq, rreq, rd[17]}, 0);
    waitn(1);
    chk(rd[17] == 1'b1, "R7 expiry edge", rd[17], 1);
    if (act == 2) chk(irq && !rreq, "R8 irq at expiry", {irq, rreq}, 2);
    else          chk(!irq && rreq, "R9 reset pulse", {irq, rreq}, 1);
    waitn(1);
    chk(!rreq, "R9 pulse one cycle", rreq, 0);
    chk(irq == (act == 2), "R8 irq sticky", irq, act == 2);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    chk(rd == 32'd0, "R1 readback zero", rd, 0);
    chk(!irq && !rreq, "R1 outputs low", {irq, rreq}, 0);
    chk(rd[31:30] == 2'b00, "R12 top bits", rd[31:30], 0);

    // directed corners
    run_case(0, 1'b0, 2);
    run_case(1, 1'b1, 1);
    run_case(5, 1'b0, 0);
    run_case(3, 1'b1, 3);

    // write-once
    do_reset();
    wr(mk(10, 1'b0, 1'b1, 2));
    waitn(4);
    wr(16'h1FF3);
    chk(rd[15:0] == mk(10, 1'b0, 1'b1, 2), "R3 setup frozen", rd[15:0], mk(10, 1'b0, 1'b1, 2));
    chk(rd[29:18] == 10, "R4 kick reload", rd[29:18], 10);

    // retrigger restarts the period
    do_reset();
    wr(mk(6, 1'b0, 1'b1, 2));
    waitn(5);
    wr(16'hFFFF);
    waitn(exp_edge(6, 1'b0) - 1);
    chk(!irq, "R4 no expiry after kick", irq, 0);
    waitn(1);
    chk(irq, "R4 expiry after kick", irq, 1);

    // retrigger restarts the prescaler phase
    do_reset();
    wr(mk(2, 1'b1, 1'b1, 2));
    waitn(7);
    wr(16'h0000);
    waitn(exp_edge(2, 1'b1) - 1);
    chk(!irq, "R4 prescaler restart early", irq, 0);
    waitn(1);
    chk(irq, "R4 prescaler restart expiry", irq, 1);

    // writes after expiry ignored
    wr(16'h2FFF);
    chk(rd[29:18] == 0 && rd[17], "R11 count held", rd[29:17], 1);
    chk(irq && !rreq, "R11 outputs held", {irq, rreq}, 2);
    chk(rd[15:0] == mk(2, 1'b1, 1'b1, 2), "R3 setup after expiry", rd[15:0], mk(2, 1'b1, 1'b1, 2));

    // enable clear
    do_reset();
    wr(mk(3, 1'b0, 1'b0, 2));
    waitn(100);
    chk(rd[29:18] == 3, "R10 count holds", rd[29:18], 3);
    chk(!irq && !rreq && !rd[17], "R10 no expiry", {irq, rreq, rd[17]}, 0);

    // random configurations
    for (int i = 0; i < 10; i++) begin
      int n   = $urandom % 24;
      bit ps  = $urandom % 2;
      int act = $urandom % 4;
      run_case(n, ps, act);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule